// File: doc/BRIEF.md
# USB Endpoint Handshake Response Controller

This block keeps one control byte for each endpoint of a small USB device and decides how the device answers every decoded token. An upstream serial engine presents one token per cycle: its kind, the endpoint it targets, whether a SETUP transaction is pending, and whether the receive buffer of that endpoint still holds an unread packet. The block answers on the next clock with a registered verdict: no reply, accept, NACK or STALL. Alongside the verdict it raises a receive-buffer write enable for accepted OUT and SETUP data, or a send strobe for an IN token whose buffered data is to go out.

Firmware reaches the control bytes through a two-register bus: an index register selects an endpoint, and the control register reads and writes the selected byte. The two endpoint-enable bits cannot be changed from the bus; a separate configuration input loads them. When the serial engine reports a malformed control status stage, the block sets the receive stall bit of that endpoint on its own, and that hardware set wins over a bus write to the same byte in the same cycle.

Top module: `usb_ep_handshake`

## Requirements
- R1: After reset, endpoint 0 holds 0x35, every other endpoint holds 0x10, the index register is 0 and rsp_valid, fifo_wr_en and tx_send are low.
- R2: The control byte is laid out from bit 7 to bit 0 as receive stall, transmit stall, control endpoint, receive single-packet, receive input enable, receive endpoint enable, transmit output enable, transmit endpoint enable. With bus_sel=0 a write loads the index from bus_wdata[1:0] and a read returns the index; with bus_sel=1 a write updates bits 7,6,5,4,3,1 of the indexed byte, leaves bits 2 and 0 unchanged, and a read returns the indexed byte.
- R3: A cycle with cfg_wr high loads bits 2 and 0 of endpoint cfg_ep from cfg_rx_en and cfg_tx_en.
- R4: Each token (tok_kind 0=OUT, 1=IN, 2=SETUP, 3=reserved) yields rsp_valid high exactly one cycle later with rsp_code 0=none, 1=accept, 2=NACK, 3=STALL; a reserved token gets code 0.
- R5: With receive endpoint enable clear, OUT and SETUP get code 0 whatever the other bits are.
- R6: An OUT to an enabled endpoint with receive stall set gets STALL when setup_pend is low and NACK when it is high.
- R7: An OUT with receive stall clear and receive input enable clear gets NACK and no buffer write.
- R8: An OUT with receive single-packet set while rx_held is high gets NACK; with single-packet clear, rx_held has no effect.
- R9: An OUT that passes every check gets accept together with fifo_wr_en.
- R10: A SETUP is accepted with fifo_wr_en only by an enabled endpoint whose control-endpoint bit is set, regardless of receive stall and input enable; otherwise it gets code 0.
- R11: An IN gets code 0 when transmit enable is clear; STALL (setup_pend low) or NACK (setup_pend high) when transmit stall is set; NACK when output enable is clear; otherwise accept with tx_send.
- R12: A status-stage report (st_valid) with st_data1 low or st_len_nz high sets bit 7 of endpoint st_ep on the next edge, even when the bus writes that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 = index register, 1 = control register |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| cfg_wr | input | 1 | Load endpoint enable bits |
| cfg_ep | input | 2 | Endpoint for the enable load |
| cfg_rx_en | input | 1 | New receive endpoint enable |
| cfg_tx_en | input | 1 | New transmit endpoint enable |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | Token kind |
| tok_ep | input | 2 | Target endpoint of the token |
| setup_pend | input | 1 | A SETUP transaction is pending |
| rx_held | input | 1 | Receive buffer still holds a packet |
| st_valid | input | 1 | Status-stage data packet report |
| st_ep | input | 2 | Endpoint of the status stage |
| st_data1 | input | 1 | Status packet carried DATA1 |
| st_len_nz | input | 1 | Status packet held one or more bytes |
| rsp_valid | output | 1 | Verdict present |
| rsp_code | output | 2 | Verdict code |
| fifo_wr_en | output | 1 | Write enable for the receive buffer |
| tx_send | output | 1 | Send buffered transmit data |

## Verification
A token presented before a rising edge produces its verdict, buffer write and send strobe in the registers loaded at that same edge, so the bench expects them one cycle after the token and compares them shortly after every edge. A bus write, an enable load or a status-stage stall set lands at that same edge too, and since the read path is combinational the new byte is expected on bus_rdata in the cycle right after the write. The verdict for a token uses the control byte as it stood before any same-cycle update, and the reference model keeps that order by deciding first and updating its copy second.

// File: rtl/ephs_pkg.sv
package ephs_pkg;

    typedef struct packed {
        logic rx_stall;
        logic tx_stall;
        logic ctl_ep;
        logic rx_single;
        logic rx_in_en;
        logic rx_ep_en;
        logic tx_out_en;
        logic tx_ep_en;
    } ep_ctl_t;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        RP_NONE   = 2'd0,
        RP_ACCEPT = 2'd1,
        RP_NACK   = 2'd2,
        RP_STALL  = 2'd3
    } reply_e;

    typedef struct packed {
        reply_e code;
        logic   fifo_wr;
        logic   tx_send;
    } verdict_t;

    localparam logic [7:0] EP0_RESET   = 8'h35;
    localparam logic [7:0] EPN_RESET   = 8'h10;
    // bits the register bus may change; the two enables stay hardware-owned
    localparam logic [7:0] BUS_WR_MASK = 8'b1111_1010;

    function automatic verdict_t judge(input ep_ctl_t c, input tok_kind_e k,
                                       input logic setup_pend, input logic rx_held);
        verdict_t v;
        v = '{code: RP_NONE, fifo_wr: 1'b0, tx_send: 1'b0};
        case (k)
            TK_OUT: begin
                if (!c.rx_ep_en)
                    v.code = RP_NONE;
                else if (c.rx_stall)
                    v.code = setup_pend ? RP_NACK : RP_STALL;
                else if (!c.rx_in_en)
                    v.code = RP_NACK;
                else if (c.rx_single && rx_held)
                    v.code = RP_NACK;
                else begin
                    v.code    = RP_ACCEPT;
                    v.fifo_wr = 1'b1;
                end
            end
            TK_SETUP: begin
                if (c.rx_ep_en && c.ctl_ep) begin
                    v.code    = RP_ACCEPT;
                    v.fifo_wr = 1'b1;
                end
            end
            TK_IN: begin
                if (!c.tx_ep_en)
                    v.code = RP_NONE;
                else if (c.tx_stall)
                    v.code = setup_pend ? RP_NACK : RP_STALL;
                else if (!c.tx_out_en)
                    v.code = RP_NACK;
                else begin
                    v.code    = RP_ACCEPT;
                    v.tx_send = 1'b1;
                end
            end
            default: v.code = RP_NONE;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ephs_regfile.sv
module ephs_regfile
    import ephs_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPW    = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic [EPW-1:0]  bus_ep,
    input  logic [7:0]      bus_wdata,
    input  logic            cfg_wr,
    input  logic [EPW-1:0]  cfg_ep,
    input  logic            cfg_rx_en,
    input  logic            cfg_tx_en,
    input  logic            hw_stall,
    input  logic [EPW-1:0]  hw_ep,
    output ep_ctl_t         ctl [NUM_EP]
);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        localparam logic [7:0] RST_VAL = (g == 0) ? EP0_RESET : EPN_RESET;
        ep_ctl_t ctl_q, ctl_d;

        always_comb begin
            ctl_d = ctl_q;
            if (bus_we && bus_ep == EPW'(g))
                ctl_d = ep_ctl_t'((bus_wdata & BUS_WR_MASK) | (ctl_q & ~BUS_WR_MASK));
            if (cfg_wr && cfg_ep == EPW'(g)) begin
                ctl_d.rx_ep_en = cfg_rx_en;
                ctl_d.tx_ep_en = cfg_tx_en;
            end
            if (hw_stall && hw_ep == EPW'(g))
                ctl_d.rx_stall = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) ctl_q <= ep_ctl_t'(RST_VAL);
            else     ctl_q <= ctl_d;
        end

        assign ctl[g] = ctl_q;
    end

endmodule

// File: rtl/ephs_busif.sv
module ephs_busif
    import ephs_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPW    = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_sel,
    input  logic [7:0]      bus_wdata,
    input  ep_ctl_t         ctl [NUM_EP],
    output logic            ctl_we,
    output logic [EPW-1:0]  sel_ep,
    output logic [7:0]      bus_rdata
);

    logic [EPW-1:0] idx_q;
    logic           idx_ok;

    assign idx_ok = int'(idx_q) < NUM_EP;
    assign sel_ep = idx_q;
    assign ctl_we = bus_wr && bus_sel && idx_ok;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (bus_wr && !bus_sel)
            idx_q <= bus_wdata[EPW-1:0];
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (!bus_sel)
            bus_rdata[EPW-1:0] = idx_q;
        else if (idx_ok)
            bus_rdata = ctl[idx_q];
    end

endmodule

// File: rtl/ephs_decide.sv
module ephs_decide
    import ephs_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPW    = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  ep_ctl_t         ctl [NUM_EP],
    input  logic            tok_valid,
    input  logic [1:0]      tok_kind,
    input  logic [EPW-1:0]  tok_ep,
    input  logic            setup_pend,
    input  logic            rx_held,
    output logic            rsp_valid,
    output logic [1:0]      rsp_code,
    output logic            fifo_wr_en,
    output logic            tx_send
);

    verdict_t v_d, v_q;
    logic     vld_q;

    always_comb begin
        v_d = '{code: RP_NONE, fifo_wr: 1'b0, tx_send: 1'b0};
        if (tok_valid && int'(tok_ep) < NUM_EP)
            v_d = judge(ctl[tok_ep], tok_kind_e'(tok_kind), setup_pend, rx_held);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            v_q   <= '{code: RP_NONE, fifo_wr: 1'b0, tx_send: 1'b0};
        end else begin
            vld_q <= tok_valid;
            v_q   <= v_d;
        end
    end

    assign rsp_valid  = vld_q;
    assign rsp_code   = v_q.code;
    assign fifo_wr_en = v_q.fifo_wr;
    assign tx_send    = v_q.tx_send;

endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
    import ephs_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_sel,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic            cfg_wr,
    input  logic [EPW-1:0]  cfg_ep,
    input  logic            cfg_rx_en,
    input  logic            cfg_tx_en,
    input  logic            tok_valid,
    input  logic [1:0]      tok_kind,
    input  logic [EPW-1:0]  tok_ep,
    input  logic            setup_pend,
    input  logic            rx_held,
    input  logic            st_valid,
    input  logic [EPW-1:0]  st_ep,
    input  logic            st_data1,
    input  logic            st_len_nz,
    output logic            rsp_valid,
    output logic [1:0]      rsp_code,
    output logic            fifo_wr_en,
    output logic            tx_send
);

    ep_ctl_t              ctl [NUM_EP];
    logic                 ctl_we;
    logic [EPW-1:0]       sel_ep;
    logic                 hw_stall;
    logic [NUM_EP*8-1:0]  ctl_flat;

    // malformed status stage: wrong data PID or a non-empty packet
    assign hw_stall = st_valid && (!st_data1 || st_len_nz);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_flat
        assign ctl_flat[g*8 +: 8] = ctl[g];
    end

    ephs_busif #(.NUM_EP(NUM_EP), .EPW(EPW)) u_bus (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .ctl(ctl), .ctl_we(ctl_we),
        .sel_ep(sel_ep), .bus_rdata(bus_rdata)
    );

    ephs_regfile #(.NUM_EP(NUM_EP), .EPW(EPW)) u_regs (
        .clk(clk), .rst(rst), .bus_we(ctl_we), .bus_ep(sel_ep),
        .bus_wdata(bus_wdata), .cfg_wr(cfg_wr), .cfg_ep(cfg_ep),
        .cfg_rx_en(cfg_rx_en), .cfg_tx_en(cfg_tx_en),
        .hw_stall(hw_stall), .hw_ep(st_ep), .ctl(ctl)
    );

    ephs_decide #(.NUM_EP(NUM_EP), .EPW(EPW)) u_dec (
        .clk(clk), .rst(rst), .ctl(ctl), .tok_valid(tok_valid),
        .tok_kind(tok_kind), .tok_ep(tok_ep), .setup_pend(setup_pend),
        .rx_held(rx_held), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .fifo_wr_en(fifo_wr_en), .tx_send(tx_send)
    );

endmodule

// File: rtl/ephs_chk.sv
module ephs_chk #(
    parameter int NUM_EP = 4,
    parameter int EPW    = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                tok_valid,
    input logic [1:0]          tok_kind,
    input logic                st_valid,
    input logic [EPW-1:0]      st_ep,
    input logic                st_data1,
    input logic                st_len_nz,
    input logic                cfg_wr,
    input logic                rsp_valid,
    input logic [1:0]          rsp_code,
    input logic                fifo_wr_en,
    input logic                tx_send,
    input logic [NUM_EP*8-1:0] ctl_flat
);

    logic                  warm;
    logic [2*NUM_EP-1:0]   en_bits;

    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    for (genvar g = 0; g < NUM_EP; g++) begin : g_en
        assign en_bits[2*g]   = ctl_flat[g*8 + 0];
        assign en_bits[2*g+1] = ctl_flat[g*8 + 2];
    end

    AST_REPLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        warm |-> (rsp_valid == $past(tok_valid))); // R4

    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(tok_valid && tok_kind == 2'd3)) |-> (rsp_code == 2'd0)); // R4

    AST_WRITE_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_en |-> (rsp_valid && rsp_code == 2'd1 && !tx_send)); // R9

    AST_SEND_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        tx_send |-> (rsp_valid && rsp_code == 2'd1)); // R11

    AST_HW_STALL_SET: assert property (@(posedge clk) disable iff (rst)
        (st_valid && (!st_data1 || st_len_nz)) |=> ctl_flat[int'($past(st_ep))*8 + 7]); // R12

    AST_ENABLES_BUS_PROOF: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(cfg_wr)) |-> $stable(en_bits)); // R2

endmodule

bind usb_ep_handshake ephs_chk #(.NUM_EP(NUM_EP), .EPW(EPW)) u_chk (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .st_valid(st_valid), .st_ep(st_ep), .st_data1(st_data1),
    .st_len_nz(st_len_nz), .cfg_wr(cfg_wr), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .fifo_wr_en(fifo_wr_en), .tx_send(tx_send),
    .ctl_flat(ctl_flat)
);

// File: tb/sim_usb_ep_handshake.sv
`timescale 1ns/1ps
module sim_usb_ep_handshake;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 0, bus_sel = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       cfg_wr = 0, cfg_rx_en = 0, cfg_tx_en = 0;
    logic [1:0] cfg_ep = 0;
    logic       tok_valid = 0, setup_pend = 0, rx_held = 0;
    logic [1:0] tok_kind = 0, tok_ep = 0;
    logic       st_valid = 0, st_data1 = 1, st_len_nz = 0;
    logic [1:0] st_ep = 0;
    logic       rsp_valid, fifo_wr_en, tx_send;
    logic [1:0] rsp_code;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    usb_ep_handshake u0 (.*);

    // reference model
    logic [7:0] m_ctl [4];
    logic [1:0] m_idx;
    logic [1:0] e_code;
    logic       e_vld, e_wr, e_send;
    logic [7:0] e_rdata;

    always @(posedge clk) begin
        logic [7:0] c;
        if (rst) begin
            m_ctl[0] = 8'h35; m_ctl[1] = 8'h10; m_ctl[2] = 8'h10; m_ctl[3] = 8'h10;
            m_idx = 0;
            e_vld = 0; e_code = 0; e_wr = 0; e_send = 0;
        end else begin
            c = m_ctl[tok_ep];
            e_vld = tok_valid; e_code = 0; e_wr = 0; e_send = 0;
            if (tok_valid) begin
                if (tok_kind == 0) begin
                    if (!c[2]) e_code = 0;
                    else if (c[7]) e_code = setup_pend ? 2 : 3;
                    else if (!c[3]) e_code = 2;
                    else if (c[4] && rx_held) e_code = 2;
                    else begin e_code = 1; e_wr = 1; end
                end else if (tok_kind == 2) begin
                    if (c[2] && c[5]) begin e_code = 1; e_wr = 1; end
                end else if (tok_kind == 1) begin
                    if (!c[0]) e_code = 0;
                    else if (c[6]) e_code = setup_pend ? 2 : 3;
                    else if (!c[1]) e_code = 2;
                    else begin e_code = 1; e_send = 1; end
                end
            end
            if (bus_wr && bus_sel) m_ctl[m_idx] = (bus_wdata & 8'hFA) | (m_ctl[m_idx] & 8'h05);
            if (bus_wr && !bus_sel) m_idx = bus_wdata[1:0];
            if (cfg_wr) begin m_ctl[cfg_ep][2] = cfg_rx_en; m_ctl[cfg_ep][0] = cfg_tx_en; end
            if (st_valid && (!st_data1 || st_len_nz)) m_ctl[st_ep][7] = 1'b1;
        end
        e_rdata = bus_sel ? m_ctl[m_idx] : {6'b0, m_idx};
        #1;
        compare();
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("rsp_valid", rsp_valid, e_vld);
        chk("rsp_code", rsp_code, e_code);
        chk("fifo_wr_en", fifo_wr_en, e_wr);
        chk("tx_send", tx_send, e_send);
        chk("bus_rdata", bus_rdata, e_rdata);
    endtask

    task automatic idle();
        bus_wr = 0; cfg_wr = 0; tok_valid = 0; st_valid = 0;
    endtask

    task automatic wreg(input logic sel, input logic [7:0] d);
        @(negedge clk); idle(); bus_wr = 1; bus_sel = sel; bus_wdata = d;
        @(negedge clk); idle(); bus_sel = 1;
    endtask

    task automatic sel_ep(input logic [1:0] ep);
        wreg(0, {6'b0, ep});
    endtask

    task automatic tok(input logic [1:0] k, input logic [1:0] ep,
                       input logic sp, input logic held);
        @(negedge clk); idle(); tok_valid = 1; tok_kind = k; tok_ep = ep;
        setup_pend = sp; rx_held = held;
        @(negedge clk); idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: defaults readable per endpoint
        cur_req = "R1";
        bus_sel = 1; @(negedge clk);
        for (int e = 1; e < 4; e++) sel_ep(e[1:0]);
        // R2: bus writes keep the enable bits
        cur_req = "R2";
        sel_ep(0); wreg(1, 8'hFF); wreg(1, 8'h00); wreg(1, 8'h30);
        bus_sel = 0; @(negedge clk); bus_sel = 1;
        // R3: enable load via configuration input
        cur_req = "R3";
        @(negedge clk); cfg_wr = 1; cfg_ep = 1; cfg_rx_en = 1; cfg_tx_en = 1;
        @(negedge clk); idle(); sel_ep(1);
        // R5: endpoint 2 receive disabled
        cur_req = "R5";
        tok(0, 2, 0, 0); tok(2, 2, 0, 0);
        // R4: reserved token
        cur_req = "R4";
        tok(3, 0, 0, 0);
        // R7: input enable clear on endpoint 1
        cur_req = "R7";
        tok(0, 1, 0, 0);
        // R8 / R9: single-packet handling
        cur_req = "R8";
        wreg(1, 8'h18); tok(0, 1, 0, 1);
        cur_req = "R9";
        tok(0, 1, 0, 0);
        cur_req = "R8";
        wreg(1, 8'h08); tok(0, 1, 0, 1);
        // R6: receive stall
        cur_req = "R6";
        wreg(1, 8'h88); tok(0, 1, 0, 0); tok(0, 1, 1, 0);
        // R10: SETUP
        cur_req = "R10";
        tok(2, 1, 0, 0);
        sel_ep(0); wreg(1, 8'hA0); tok(2, 0, 0, 0);
        // R11: IN ordering
        cur_req = "R11";
        tok(1, 0, 0, 0); wreg(1, 8'hA2); tok(1, 0, 0, 0);
        wreg(1, 8'hE2); tok(1, 0, 0, 0); tok(1, 0, 1, 0); tok(1, 3, 0, 0);
        // R12: hardware stall, and its priority over a bus write
        cur_req = "R12";
        sel_ep(2);
        @(negedge clk); st_valid = 1; st_ep = 2; st_data1 = 0; st_len_nz = 0;
        @(negedge clk); idle();
        @(negedge clk); st_valid = 1; st_ep = 1; st_data1 = 1; st_len_nz = 0;
        @(negedge clk); idle();
        sel_ep(3);
        @(negedge clk); bus_wr = 1; bus_sel = 1; bus_wdata = 8'h00;
        st_valid = 1; st_ep = 3; st_data1 = 1; st_len_nz = 1;
        @(negedge clk); idle(); @(negedge clk);
        // R4: mixed random traffic against the model
        cur_req = "R4";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            bus_wr = ($urandom_range(0, 5) == 0); bus_sel = $urandom_range(0, 1);
            bus_wdata = 8'($urandom);
            cfg_wr = ($urandom_range(0, 7) == 0); cfg_ep = 2'($urandom);
            cfg_rx_en = $urandom_range(0, 1); cfg_tx_en = $urandom_range(0, 1);
            tok_valid = $urandom_range(0, 1); tok_kind = 2'($urandom); tok_ep = 2'($urandom);
            setup_pend = $urandom_range(0, 1); rx_held = $urandom_range(0, 1);
            st_valid = ($urandom_range(0, 9) == 0); st_ep = 2'($urandom);
            st_data1 = $urandom_range(0, 1); st_len_nz = $urandom_range(0, 1);
        end
        @(negedge clk); idle(); @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired during %s actual=1 expected=0", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule